// File: doc/BRIEF.md
# Hierarchical Idle Power State Controller

This block governs the idle behaviour of a small cluster of cores sharing one cache level. Each core asks to run, to wait with its context kept, or to shut down with its context lost. One core, fixed by parameter, may also ask for the whole cluster to go down. The block turns these requests into clock-gate, power-gate, retention and reset controls for the cores and the shared cache. It runs the cache clean handshake before power-off and the invalidate handshake on the way back up.

While the cache is held in retention, snoops wake it without help from any core. A status bit flags the longer snoop latency of that state. Interrupt and timer wake events pull cores and the cluster back to work. A wake event also cancels a cluster power-down that has not yet cut power. A programmable watchdog guards both cache handshakes.

Top module: `idle_pwr_ctl`

## Requirements
- R1: After reset every core is running (clock on, powered, out of reset), the cluster is running, no handshake is requested, `err_o` is 0 and `state_id_o` is 6'b000100.
- R2: A core requesting code 2'b01 (wait) with no wake event pending has its clock stopped while staying powered and out of reset. When its wake line is high and the cluster is running, it returns to running with no reset.
- R3: A core requesting code 2'b10 (shutdown) is unpowered and held in reset. When woken it is powered again but stays in reset until the cluster is running.
- R4: A cluster request is taken only from the designated core's 2-bit field in `core_cl_req_i` (field i at bits 2i+1:2i; 01 retain, 10 cluster off, 11 system off). It starts only when every core is waiting or shut down and no wake event is pending.
- R5: On a retain request the cache enters retention: `cl_ret_o` 1, cluster clock off, power on, `snp_slow_o` 1.
- R6: In retention a snoop request turns the cache clock on and drops retention while `snp_slow_o` stays 1, with no change to any core output. Retention resumes once the snoop line falls.
- R7: On an off request `clean_req_o` is raised first. Cluster power drops only after `clean_done_i`.
- R8: A wake from cluster power-off restores cluster power, waits for `pwr_good_i`, raises `inval_req_o`, and releases woken cores' resets only in the cycle after the invalidate completes.
- R9: Any wake event during the clean cancels the power-down and returns the cluster to running, cache powered and clocked.
- R10: If a clean or invalidate handshake is still open after `wdog_lim_i` cycles (at least 1), `err_o` is set until reset, the cluster returns to running, and further cluster requests are refused.
- R11: `ext_tmr_req_o` is high whenever any core or the cluster is powered off.
- R12: `gic_save_o` is high during the clean of a system-off request (11) only.
- R13: `state_id_o` = {type, level, sub}, with type 0 running, 1 waiting, 2 shutdown, so a deeper state has a larger code. Cluster running is 000100, a transition is 000101, retention is 010100, cluster off is 100100 and system off is 101000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| core_req_i | input | 2*N_CORES | Per-core target: 00 run, 01 wait, 10 shutdown |
| core_cl_req_i | input | 2*N_CORES | Per-core cluster target; only the designated core's field is used |
| wake_irq_i | input | N_CORES | Interrupt wake level per core |
| wake_tmr_i | input | N_CORES | Timer wake level per core |
| snoop_req_i | input | 1 | Snoop pending for the shared cache |
| clean_done_i | input | 1 | Cache clean complete |
| inval_done_i | input | 1 | Cache invalidate complete |
| pwr_good_i | input | 1 | Cluster power rail stable |
| wdog_lim_i | input | WDOG_W | Handshake timeout in cycles |
| core_clk_en_o | output | N_CORES | Core clock enable |
| core_pwr_en_o | output | N_CORES | Core power enable |
| core_rst_o | output | N_CORES | Core reset hold, active high |
| cl_pwr_en_o | output | 1 | Cluster power enable |
| cl_clk_en_o | output | 1 | Cluster clock enable |
| cl_ret_o | output | 1 | Cache retention |
| snp_slow_o | output | 1 | Cache retained; snoops see extra latency |
| clean_req_o | output | 1 | Cache clean request |
| inval_req_o | output | 1 | Cache invalidate request |
| ext_tmr_req_o | output | 1 | External wake timer needed |
| gic_save_o | output | 1 | Interrupt-controller state save request |
| err_o | output | 1 | Handshake timeout, sticky |
| state_id_o | output | 6 | Encoded cluster state |

## Verification
The bench targets the orderings. It checks that power drops only after the clean finishes, and that a woken core is still held in reset during the power-good wait and the invalidate. A design that freed the reset early would let a core run on a stale cache. It also checks that a snoop in retention leaves every core output unchanged and that a wake in mid-clean cancels the power-down rather than cutting power. Other checks cover a cluster request from a core other than the designated one, a watchdog expiry that would otherwise re-enter the clean endlessly, and the save flag, which must appear only for the system-off target.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  typedef enum logic [1:0] {C_RUN = 2'd0, C_WAIT = 2'd1, C_OFF = 2'd2, C_BOOT = 2'd3} core_st_e;
  typedef enum logic [2:0] {L_RUN, L_CLEAN, L_OFF, L_PWRUP, L_INV, L_RET, L_SNP} clu_st_e;

  localparam logic [1:0] REQ_WAIT = 2'b01;
  localparam logic [1:0] TGT_NONE = 2'b00;
  localparam logic [1:0] TGT_RET  = 2'b01;
  localparam logic [1:0] TGT_SYS  = 2'b11;
  localparam logic [1:0] ID_R     = 2'd0;
  localparam logic [1:0] ID_W     = 2'd1;
  localparam logic [1:0] ID_S     = 2'd2;

  function automatic logic [5:0] mk_id(logic [1:0] typ, logic [1:0] lvl, logic [1:0] sub);
    return {typ, lvl, sub};
  endfunction
endpackage

// File: rtl/ipc_wdog.sv
module ipc_wdog #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         act_i,
  input  logic         done_i,
  input  logic [W-1:0] lim_i,
  output logic         tmo_o
);
  logic [W-1:0] cnt_q;

  assign tmo_o = act_i && !done_i && (cnt_q == lim_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!act_i)             cnt_q <= '0;
    else if (!done_i && !tmo_o)  cnt_q <= cnt_q + 1'b1;
  end

  AST_WDOG_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && lim_i != '0) |-> (cnt_q < lim_i)) else $error("wdog count past limit"); // R10
endmodule

// File: rtl/ipc_core.sv
module ipc_core
  import ipc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] req_i,
  input  logic       wake_i,
  input  logic       cl_ready_i,
  input  logic       cl_off_i,
  output core_st_e   st_o,
  output logic       clk_en_o,
  output logic       pwr_en_o,
  output logic       rst_o
);
  core_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      C_RUN:  if (!wake_i) begin
                if (req_i[1])              st_d = C_OFF;
                else if (req_i == REQ_WAIT) st_d = C_WAIT;
              end
      C_WAIT: if (cl_off_i)                st_d = C_OFF;   // context lost with cluster rail
              else if (wake_i && cl_ready_i) st_d = C_RUN;
      C_OFF:  if (wake_i)                  st_d = C_BOOT;
      C_BOOT: if (cl_ready_i)              st_d = C_RUN;
      default:                             st_d = C_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= C_RUN;
    else         st_q <= st_d;
  end

  assign st_o     = st_q;
  assign clk_en_o = (st_q == C_RUN) || (st_q == C_BOOT);
  assign pwr_en_o = (st_q != C_OFF);
  assign rst_o    = (st_q == C_OFF) || (st_q == C_BOOT);

  AST_RST_AFTER_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> $past(cl_ready_i)) else $error("reset freed before cluster ready"); // R8
  AST_WAIT_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == C_WAIT && st_q == C_RUN) |-> $past(wake_i)) else $error("wait exit without wake"); // R2
endmodule

// File: rtl/ipc_cluster.sv
module ipc_cluster
  import ipc_pkg::*;
#(
  parameter int WDOG_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              all_idle_i,
  input  logic [1:0]        tgt_i,
  input  logic              wake_any_i,
  input  logic              snoop_i,
  input  logic              clean_done_i,
  input  logic              inval_done_i,
  input  logic              pwr_good_i,
  input  logic [WDOG_W-1:0] wdog_lim_i,
  output logic              pwr_en_o,
  output logic              clk_en_o,
  output logic              ret_o,
  output logic              snp_slow_o,
  output logic              clean_req_o,
  output logic              inval_req_o,
  output logic              gic_save_o,
  output logic              err_o,
  output logic              ready_o,
  output logic              off_o,
  output logic [5:0]        id_o
);
  clu_st_e    st_q, st_d;
  logic [1:0] tgt_q;
  logic       err_q, err_set, tmo, hs_act, hs_done;

  assign hs_act  = (st_q == L_CLEAN) || (st_q == L_INV);
  assign hs_done = (st_q == L_CLEAN) ? clean_done_i : inval_done_i;

  ipc_wdog #(.W(WDOG_W)) u_wdog (
    .clk_i (clk_i), .rst_ni(rst_ni), .act_i(hs_act), .done_i(hs_done),
    .lim_i (wdog_lim_i), .tmo_o(tmo)
  );

  always_comb begin
    st_d    = st_q;
    err_set = 1'b0;
    case (st_q)
      L_RUN:   if (all_idle_i && tgt_i != TGT_NONE && !wake_any_i && !err_q)
                 st_d = (tgt_i == TGT_RET) ? L_RET : L_CLEAN;
      L_CLEAN: if (wake_any_i)        st_d = L_RUN;   // abort before power gate
               else if (clean_done_i) st_d = L_OFF;
               else if (tmo) begin    st_d = L_RUN; err_set = 1'b1; end
      L_OFF:   if (wake_any_i)        st_d = L_PWRUP;
      L_PWRUP: if (pwr_good_i)        st_d = L_INV;
      L_INV:   if (inval_done_i)      st_d = L_RUN;
               else if (tmo) begin    st_d = L_RUN; err_set = 1'b1; end
      L_RET:   if (wake_any_i)        st_d = L_RUN;
               else if (snoop_i)      st_d = L_SNP;
      L_SNP:   if (wake_any_i)        st_d = L_RUN;
               else if (!snoop_i)     st_d = L_RET;
      default:                        st_d = L_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= L_RUN;
      tgt_q <= TGT_NONE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_q | err_set;
      if (st_q == L_RUN && st_d == L_CLEAN) tgt_q <= tgt_i;
    end
  end

  assign pwr_en_o    = (st_q != L_OFF);
  assign clk_en_o    = (st_q == L_RUN) || (st_q == L_CLEAN) || (st_q == L_INV) || (st_q == L_SNP);
  assign ret_o       = (st_q == L_RET);
  assign snp_slow_o  = (st_q == L_RET) || (st_q == L_SNP);
  assign clean_req_o = (st_q == L_CLEAN);
  assign inval_req_o = (st_q == L_INV);
  assign gic_save_o  = (st_q == L_CLEAN) && (tgt_q == TGT_SYS);
  assign err_o       = err_q;
  assign ready_o     = (st_q == L_RUN);
  assign off_o       = (st_q == L_OFF);

  always_comb begin
    case (st_q)
      L_RUN:          id_o = mk_id(ID_R, 2'd1, 2'd0);
      L_RET, L_SNP:   id_o = mk_id(ID_W, 2'd1, 2'd0);
      L_OFF:          id_o = (tgt_q == TGT_SYS) ? mk_id(ID_S, 2'd2, 2'd0) : mk_id(ID_S, 2'd1, 2'd0);
      default:        id_o = mk_id(ID_R, 2'd1, 2'd1);
    endcase
  end

  AST_OFF_AFTER_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == L_OFF && $past(st_q) != L_OFF) |-> ($past(st_q) == L_CLEAN && $past(clean_done_i)))
    else $error("power off without clean"); // R7
  AST_INV_AFTER_PGOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inval_req_o) |-> $past(pwr_good_i)) else $error("invalidate before power good"); // R8
  AST_ENTRY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == L_RUN && st_q != L_RUN) |-> $past(all_idle_i) && !$past(wake_any_i))
    else $error("cluster left running with a core active"); // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_q) |-> err_q) else $error("error flag cleared"); // R10
endmodule

// File: rtl/idle_pwr_ctl.sv
module idle_pwr_ctl
  import ipc_pkg::*;
#(
  parameter int N_CORES  = 4,
  parameter int LAST_MAN = 0,
  parameter int WDOG_W   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2*N_CORES-1:0] core_req_i,
  input  logic [2*N_CORES-1:0] core_cl_req_i,
  input  logic [N_CORES-1:0]   wake_irq_i,
  input  logic [N_CORES-1:0]   wake_tmr_i,
  input  logic                 snoop_req_i,
  input  logic                 clean_done_i,
  input  logic                 inval_done_i,
  input  logic                 pwr_good_i,
  input  logic [WDOG_W-1:0]    wdog_lim_i,
  output logic [N_CORES-1:0]   core_clk_en_o,
  output logic [N_CORES-1:0]   core_pwr_en_o,
  output logic [N_CORES-1:0]   core_rst_o,
  output logic                 cl_pwr_en_o,
  output logic                 cl_clk_en_o,
  output logic                 cl_ret_o,
  output logic                 snp_slow_o,
  output logic                 clean_req_o,
  output logic                 inval_req_o,
  output logic                 ext_tmr_req_o,
  output logic                 gic_save_o,
  output logic                 err_o,
  output logic [5:0]           state_id_o
);
  localparam int REQ_W = 2 * N_CORES;

  core_st_e             core_st [N_CORES];
  logic [N_CORES-1:0]   wake;
  logic                 wake_any, all_idle, any_off, cl_ready, cl_off;
  logic [1:0]           tgt;
  logic [REQ_W-1:0]     req_unused;

  assign wake     = wake_irq_i | wake_tmr_i;
  assign wake_any = |wake;

  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    ipc_core u_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (core_req_i[2*i +: 2]),
      .wake_i    (wake[i]),
      .cl_ready_i(cl_ready),
      .cl_off_i  (cl_off),
      .st_o      (core_st[i]),
      .clk_en_o  (core_clk_en_o[i]),
      .pwr_en_o  (core_pwr_en_o[i]),
      .rst_o     (core_rst_o[i])
    );
  end

  // only the designated core may name a cluster target
  always_comb begin
    tgt        = TGT_NONE;
    req_unused = '0;
    all_idle   = 1'b1;
    any_off    = 1'b0;
    for (int i = 0; i < N_CORES; i++) begin
      if (i == LAST_MAN) tgt = core_cl_req_i[2*i +: 2];
      else               req_unused[2*i +: 2] = core_cl_req_i[2*i +: 2];
      if (core_st[i] != C_WAIT && core_st[i] != C_OFF) all_idle = 1'b0;
      if (core_st[i] == C_OFF) any_off = 1'b1;
    end
  end

  ipc_cluster #(.WDOG_W(WDOG_W)) u_cluster (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .all_idle_i  (all_idle),
    .tgt_i       (tgt),
    .wake_any_i  (wake_any),
    .snoop_i     (snoop_req_i),
    .clean_done_i(clean_done_i),
    .inval_done_i(inval_done_i),
    .pwr_good_i  (pwr_good_i),
    .wdog_lim_i  (wdog_lim_i),
    .pwr_en_o    (cl_pwr_en_o),
    .clk_en_o    (cl_clk_en_o),
    .ret_o       (cl_ret_o),
    .snp_slow_o  (snp_slow_o),
    .clean_req_o (clean_req_o),
    .inval_req_o (inval_req_o),
    .gic_save_o  (gic_save_o),
    .err_o       (err_o),
    .ready_o     (cl_ready),
    .off_o       (cl_off),
    .id_o        (state_id_o)
  );

  assign ext_tmr_req_o = any_off | cl_off;

  AST_SNOOP_NO_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(snp_slow_o) && snp_slow_o) |-> $stable(core_rst_o) && $stable(core_pwr_en_o))
    else $error("snoop service touched a core"); // R6
  AST_EXT_TMR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~core_pwr_en_o != '0) |-> ext_tmr_req_o) else $error("no external timer for off core"); // R11
endmodule

// File: tb/idle_pwr_ctl_tb.sv
module idle_pwr_ctl_tb;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2*N-1:0] core_req = '0, cl_req = '0;
  logic [N-1:0]   irq = '0, tmr = '0;
  logic snoop = 0, cdone = 0, idone = 0, pgood = 0;
  logic [7:0] lim = 8'd8;

  logic [N-1:0] core_clk, core_pwr, core_rst;
  logic cl_pwr, cl_clk, cl_ret, slow, clean_req, inval_req, ext_tmr, gic, err;
  logic [5:0] sid;

  int total = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  idle_pwr_ctl #(.N_CORES(N), .LAST_MAN(0), .WDOG_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .core_req_i(core_req), .core_cl_req_i(cl_req),
    .wake_irq_i(irq), .wake_tmr_i(tmr), .snoop_req_i(snoop), .clean_done_i(cdone),
    .inval_done_i(idone), .pwr_good_i(pgood), .wdog_lim_i(lim),
    .core_clk_en_o(core_clk), .core_pwr_en_o(core_pwr), .core_rst_o(core_rst),
    .cl_pwr_en_o(cl_pwr), .cl_clk_en_o(cl_clk), .cl_ret_o(cl_ret), .snp_slow_o(slow),
    .clean_req_o(clean_req), .inval_req_o(inval_req), .ext_tmr_req_o(ext_tmr),
    .gic_save_o(gic), .err_o(err), .state_id_o(sid)
  );

  wire [26:0] obs = {core_clk, core_pwr, core_rst, cl_pwr, cl_clk, cl_ret, slow,
                     clean_req, inval_req, ext_tmr, gic, err, sid};

  // stim {core_req, cl_req, irq, tmr, snoop, cdone, idone, pgood} ; exp = obs
  localparam logic [54:0] VEC [8] = '{
    {8'b01010101, 8'h00, 4'h0, 4'h0, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 9'b110000000, 6'b000100}, // R2
    {8'b01010101, 8'h01, 4'h0, 4'h0, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 9'b101100000, 6'b010100}, // R5
    {8'b01010101, 8'h01, 4'h0, 4'h0, 4'b1000, 4'b0000, 4'b1111, 4'b0000, 9'b110100000, 6'b010100}, // R6
    {8'b01010101, 8'h01, 4'h0, 4'h0, 4'b1000, 4'b0000, 4'b1111, 4'b0000, 9'b110100000, 6'b010100}, // R6
    {8'b01010101, 8'h01, 4'h0, 4'h0, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 9'b101100000, 6'b010100}, // R6
    {8'b01010101, 8'h01, 4'b0100, 4'h0, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 9'b110000000, 6'b000100}, // R5
    {8'b01000101, 8'h01, 4'b0100, 4'h0, 4'b0000, 4'b0100, 4'b1111, 4'b0000, 9'b110000000, 6'b000100}, // R2
    {8'b01000101, 8'h01, 4'h0, 4'h0, 4'b0000, 4'b0100, 4'b1111, 4'b0000, 9'b110000000, 6'b000100}  // R4
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    core_req = '0; cl_req = '0; irq = '0; tmr = '0;
    snoop = 0; cdone = 0; idone = 0; pgood = 0; lim = 8'd8;
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 reset outputs", {5'd0, obs}, {5'd0, 4'hF, 4'hF, 4'h0, 9'b110000000, 6'b000100});
    chk("R13 reset id", {26'd0, sid}, 32'b000100);

    // table walk: wait, retention, snoop service, wake
    for (int r = 0; r < 8; r++) begin
      {core_req, cl_req, irq, tmr, snoop, cdone, idone, pgood} = VEC[r][54:27];
      tick();
      chk($sformatf("R2 R5 R6 R4 table row %0d", r), {5'd0, obs}, {5'd0, VEC[r][26:0]});
    end

    // R7 R8 R3 R11: cluster off and wake order
    do_reset();
    core_req = 8'b10101010; cl_req = 8'h02;
    tick();
    chk("R3 cores off", {core_pwr, core_rst, core_clk}, {4'h0, 4'hF, 4'h0});
    chk("R11 ext timer core off", ext_tmr, 1);
    tick();
    chk("R7 clean requested", {clean_req, cl_pwr}, 2'b11);
    chk("R13 transition id", sid, 6'b000101);
    chk("R12 no save for cluster off", gic, 0);
    tick();
    chk("R7 power held until done", {clean_req, cl_pwr}, 2'b11);
    cdone = 1;
    tick();
    cdone = 0;
    chk("R7 power off after clean", {clean_req, cl_pwr, cl_clk}, 3'b000);
    chk("R13 cluster off id", sid, 6'b100100);
    chk("R11 ext timer cluster off", ext_tmr, 1);
    irq = 4'b0010;
    tick();
    chk("R3 woken core powered in reset", {core_pwr[1], core_rst[1]}, 2'b11);
    chk("R8 cluster power on", {cl_pwr, inval_req}, 2'b10);
    tick();
    chk("R8 wait power good", {inval_req, core_rst[1]}, 2'b01);
    pgood = 1;
    tick();
    pgood = 0;
    chk("R8 invalidate after power good", {inval_req, core_rst[1]}, 2'b11);
    idone = 1;
    tick();
    idone = 0;
    chk("R8 reset held as cluster resumes", {inval_req, core_rst[1], sid}, {2'b01, 6'b000100});
    tick();
    chk("R8 reset freed after invalidate", {core_rst[1], core_clk[1]}, 2'b01);
    chk("R3 others stay off", {core_pwr[3:2], core_pwr[0]}, 3'b000);

    // R9: abort in clean
    do_reset();
    core_req = 8'b01010101; cl_req = 8'h02;
    tick(); tick();
    chk("R9 in clean", clean_req, 1);
    tmr = 4'b1000;
    tick();
    chk("R9 abort keeps cache up", {clean_req, cl_pwr, cl_clk}, 3'b011);
    chk("R9 abort id", sid, 6'b000100);

    // R10: watchdog
    do_reset();
    lim = 8'd4;
    core_req = 8'b01010101; cl_req = 8'h02;
    tick(); tick();
    tick(); tick(); tick();
    chk("R10 clean still open", {clean_req, err}, 2'b10);
    tick();
    chk("R10 timeout", {clean_req, err, cl_pwr}, 3'b011);
    tick(); tick();
    chk("R10 no re-entry after error", {clean_req, err, sid}, {2'b01, 6'b000100});

    // R4: last-man rule
    do_reset();
    core_req = 8'b01010100; cl_req = 8'h02;
    tick(); tick(); tick();
    chk("R4 designated core running blocks", clean_req, 0);
    core_req = 8'b01010101; cl_req = 8'h08;
    tick(); tick(); tick();
    chk("R4 other core request ignored", {clean_req, cl_ret}, 2'b00);
    cl_req = 8'h0A;
    tick();
    chk("R4 designated request taken", clean_req, 1);

    // R12: system off
    do_reset();
    core_req = 8'b10101010; cl_req = 8'h03;
    tick(); tick();
    chk("R12 save during system clean", {gic, clean_req}, 2'b11);
    cdone = 1;
    tick();
    cdone = 0;
    chk("R12 save drops at power off", gic, 0);
    chk("R13 system off id", sid, 6'b101000);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule